// File: doc/BRIEF.md
# Link-Side Bus Turnaround Controller

This block sits on the link side of an 8-bit data bus. The bus is shared with a USB transceiver that uses the ULPI signalling style. Every cycle it decides whether the link may drive the bus. It gives an output enable and drive data to a separate tristate pad wrapper, and it raises a flag on each turnaround cycle. The transceiver takes the bus by raising `phy_dir`. The link must then let go at once, through logic with no register in the path. When `phy_dir` falls, the link waits one full clock before it drives again, so the two sets of drivers never overlap.

While the transceiver owns the bus, bytes are captured from `bus_in`. The cycle in which ownership changes is skipped, because the transceiver has not yet driven anything. While the link owns the bus, it takes bytes from a ready/valid user port. It holds each byte on the bus until the transceiver accepts it with `phy_nxt`. After the last byte it closes the transfer with a one-cycle `stp` pulse and then returns to driving zero. If the transceiver claims the bus in the middle of a transfer, the transfer is dropped and the user port is told that it was cut off.

Top module: `ulpi_turnaround_link`

## Requirements
- R1: While reset is active, and in the cycles that follow it with `phy_dir` low, `bus_oe` is 1 and `bus_out` is 8'h00. In the same state `stp`, `rx_valid` and `tx_abort` are 0.
- R2: In any cycle where `phy_dir` is 1, `bus_oe` is 0 in that same cycle, with no clock edge in between.
- R3: In the first cycle after `phy_dir` falls, `bus_oe` stays 0. It returns to 1 in the next cycle if `phy_dir` is still low.
- R4: `turn_cycle` is 1 exactly in those cycles where `phy_dir` differs from its value at the previous clock edge.
- R5: A receive byte is captured only at an edge where `phy_dir` was high both in the current cycle and in the cycle before. The byte appears on `rx_data` with `rx_valid` = 1 in the following cycle. The first high-`phy_dir` cycle is never captured.
- R6: Whenever no transmit byte is on the bus, including the cycle after reset and after a transfer, `bus_out` is 8'h00.
- R7: A byte taken with `tx_valid` and `tx_ready` appears on `bus_out` in the next cycle. It stays there unchanged until an edge where `phy_nxt` is 1 and `bus_oe` is 1.
- R8: `tx_ready` is 1 only while `bus_oe` is 1. It is asserted when the controller is idle, or when it is sending, `phy_nxt` is 1 and the byte on the bus is not marked `tx_last`.
- R9: After the last byte is accepted, `stp` is 1 for exactly one cycle with `bus_out` 8'h00, and the block then goes idle. The last byte is either one marked `tx_last`, or one accepted while `tx_valid` is low.
- R10: If `phy_dir` is 1 while a byte is on the bus, `tx_abort` is 1 in that same cycle. The byte is then abandoned and the block is idle from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock from the transceiver |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_dir | input | 1 | Bus ownership from the transceiver; 1 means the transceiver owns the bus |
| phy_nxt | input | 1 | Transceiver throttle; 1 means the byte now on the bus is accepted |
| bus_in | input | 8 | Bus value read back from the pad |
| bus_out | output | 8 | Value the link drives toward the pad |
| bus_oe | output | 1 | Pad output enable for the link drivers |
| stp | output | 1 | End-of-transfer strobe toward the transceiver |
| turn_cycle | output | 1 | High during a turnaround cycle |
| rx_data | output | 8 | Last captured receive byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_data` |
| tx_data | input | 8 | Transmit byte from the user |
| tx_last | input | 1 | Marks `tx_data` as the final byte |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | The offered byte is taken at this edge |
| tx_abort | output | 1 | The transfer in progress was cut off by the transceiver |

## Verification
The bench drives four directed patterns, then thousands of random cycles.
- A single ownership pulse of one cycle tells the combinational release apart from a registered one, and the one-cycle hold-off apart from none.
- A long receive burst shows whether the first high-`phy_dir` cycle is dropped while every later byte is kept.
- A transmit packet with `phy_nxt` held low for several cycles shows whether bytes are held or advanced too early.
- A transfer cut short by `phy_dir` separates a clean abort from a late release.

The random phase mixes ownership flips, throttling and packet lengths. This reaches turnarounds that land on the `stp` cycle and on the first byte of a packet.

// File: rtl/ulpi_turnaround_link.sv
module ulpi_turnaround_link #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          phy_dir,
  input  logic          phy_nxt,
  input  logic [DW-1:0] bus_in,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  output logic          stp,
  output logic          turn_cycle,
  output logic [DW-1:0] rx_data,
  output logic          rx_valid,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_last,
  input  logic          tx_valid,
  output logic          tx_ready,
  output logic          tx_abort
);

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_STOP} st_t;

  st_t           st;
  logic          dir_q;
  logic [DW-1:0] hold_d;
  logic          hold_last;

  assign bus_oe     = ~phy_dir & ~dir_q;
  assign turn_cycle = phy_dir ^ dir_q;
  assign bus_out    = (st == S_SEND) ? hold_d : '0;
  assign stp        = (st == S_STOP);
  assign tx_abort   = (st == S_SEND) & phy_dir;
  assign tx_ready   = bus_oe & ((st == S_IDLE) | ((st == S_SEND) & phy_nxt & ~hold_last));

  wire take = tx_valid & tx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q    <= 1'b0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      dir_q    <= phy_dir;
      rx_valid <= phy_dir & dir_q;
      if (phy_dir & dir_q) rx_data <= bus_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      hold_d    <= '0;
      hold_last <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (take) begin
          st        <= S_SEND;
          hold_d    <= tx_data;
          hold_last <= tx_last;
        end
        S_SEND: begin
          if (phy_dir) st <= S_IDLE;
          else if (bus_oe & phy_nxt) begin
            if (take) begin
              hold_d    <= tx_data;
              hold_last <= tx_last;
            end else begin
              st <= S_STOP;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    phy_dir |-> !bus_oe);

  p_reenable_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(phy_dir) |-> !bus_oe);

  p_rx_after_turn_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> ($past(phy_dir) && !$past(turn_cycle)));

  p_hold_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SEND && !phy_nxt && !phy_dir) |=> $stable(bus_out));

  p_ready_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> bus_oe);

  p_stp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    stp |-> (bus_out == '0) ##1 !stp);

  p_abort_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tx_abort |=> (!tx_abort && bus_out == '0));

endmodule

// File: tb/ulpi_turnaround_link_tb.sv
`timescale 1ns/1ps
module ulpi_turnaround_link_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic phy_dir = 1'b0, phy_nxt = 1'b0, tx_last = 1'b0, tx_valid = 1'b0;
  logic [7:0] bus_in = 8'h00, tx_data = 8'h00;
  logic [7:0] bus_out, rx_data;
  logic bus_oe, stp, turn_cycle, rx_valid, tx_ready, tx_abort;

  int total = 0, bad = 0;
  bit done = 0;

  // model state
  int m_st = 0;
  logic m_dirq = 0, m_last = 0, m_rxv = 0, m_dir_prev = 0;
  logic [7:0] m_hold = 0, m_rxd = 0;

  always #2.5 clk = ~clk;

  ulpi_turnaround_link u_dut (
    .clk(clk), .rst_n(rst_n), .phy_dir(phy_dir), .phy_nxt(phy_nxt), .bus_in(bus_in),
    .bus_out(bus_out), .bus_oe(bus_oe), .stp(stp), .turn_cycle(turn_cycle),
    .rx_data(rx_data), .rx_valid(rx_valid), .tx_data(tx_data), .tx_last(tx_last),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_abort(tx_abort));

  function automatic logic e_oe();      return !phy_dir && !m_dirq; endfunction
  function automatic logic e_rdy();     return e_oe() && (m_st == 0 || (m_st == 1 && phy_nxt && !m_last)); endfunction
  function automatic logic [7:0] e_out(); return (m_st == 1) ? m_hold : 8'h00; endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    check("R2/R3 bus_oe", int'(bus_oe), int'(e_oe()));
    check("R4 turn_cycle", int'(turn_cycle), int'(phy_dir != m_dirq));
    check("R6/R7 bus_out", int'(bus_out), int'(e_out()));
    check("R9 stp", int'(stp), int'(m_st == 2));
    check("R8 tx_ready", int'(tx_ready), int'(e_rdy()));
    check("R10 tx_abort", int'(tx_abort), int'(m_st == 1 && phy_dir));
    check("R5 rx_valid", int'(rx_valid), int'(m_rxv));
    if (m_rxv) check("R5 rx_data", int'(rx_data), int'(m_rxd));
    // the transceiver drives from the cycle after it raises phy_dir
    check("R2 no contention", int'(bus_oe && phy_dir && m_dir_prev), 0);
  endtask

  task automatic step_model();
    logic oe, rdy, take;
    oe = e_oe(); rdy = e_rdy(); take = tx_valid && rdy;
    m_rxv = phy_dir && m_dirq;
    if (m_rxv) m_rxd = bus_in;
    case (m_st)
      0: if (take) begin m_st = 1; m_hold = tx_data; m_last = tx_last; end
      1: if (phy_dir) m_st = 0;
         else if (oe && phy_nxt) begin
           if (take) begin m_hold = tx_data; m_last = tx_last; end
           else m_st = 2;
         end
      default: m_st = 0;
    endcase
    m_dir_prev = phy_dir;
    m_dirq = phy_dir;
  endtask

  task automatic cyc(logic d, logic n, logic v, logic l, logic [7:0] td, logic [7:0] bi);
    phy_dir = d; phy_nxt = n; tx_valid = v; tx_last = l; tx_data = td; bus_in = bi;
    @(negedge clk);
    check_all();
    @(posedge clk);
    step_model();
    #1;
  endtask

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 bus_oe in reset", int'(bus_oe), 1);
    check("R1 bus_out in reset", int'(bus_out), 0);
    check("R1 stp in reset", int'(stp), 0);
    check("R1 rx_valid in reset", int'(rx_valid), 0);
    check("R1 tx_abort in reset", int'(tx_abort), 0);
    @(posedge clk); #1; rst_n = 1'b1;
    cyc(0, 0, 0, 0, 0, 0);
    check("R1 bus_oe after reset", int'(bus_oe), 1);
    // one-cycle ownership pulse (R2, R3)
    cyc(1, 0, 0, 0, 0, 8'h11);
    cyc(0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0);
    // receive burst (R5)
    for (int i = 0; i < 6; i++) cyc(1, 0, 0, 0, 0, 8'hA0 + 8'(i));
    cyc(0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0);
    // throttled three-byte packet (R7, R8, R9)
    cyc(0, 0, 1, 0, 8'h41, 0);
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0, 8'h42, 0);
    cyc(0, 1, 1, 0, 8'h42, 0);
    cyc(0, 0, 1, 1, 8'h43, 0);
    cyc(0, 1, 1, 1, 8'h43, 0);
    cyc(0, 1, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0);
    // transfer cut off (R10)
    cyc(0, 0, 1, 0, 8'h77, 0);
    cyc(0, 1, 1, 0, 8'h78, 0);
    cyc(1, 0, 0, 0, 0, 8'h55);
    cyc(1, 0, 0, 0, 0, 8'h56);
    cyc(0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic d;
      d = phy_dir;
      if ($urandom_range(0, 7) == 0) d = ~d;
      cyc(d, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0),
          1'($urandom_range(0, 3) == 0), 8'($urandom), 8'($urandom));
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule